// File: doc/BRIEF.md
# Serial Control Register Port

This block is a four-wire serial control slave. It lets an external microcontroller write and read a small bank of 8-bit configuration registers. Each transaction is one 24-bit word on a data-in line. The word is framed by an active-low latch and shifted by a serial clock that has no fixed phase or rate relation to the rest of the chip. The block oversamples the three serial inputs with its own system clock, which must run well above the serial clock (at least ten times faster).

The word carries a chip address, a direction flag, a register address and a data byte. A word addressed to another chip is ignored. A word of the wrong length changes nothing. A write takes effect only when the latch is released. A read returns the addressed byte on a serial output with its own drive enable, so the output can be tri-stated at the pad. One bit of register 1 is not stored: it mirrors a phase-lock status input and cannot be written. The stored register contents leave the block on a flat bus that feeds the functions they configure.

Top module: `spi_ctl_port`

## Requirements
- R1: A frame is sent MSB first on rising serial-clock edges while the latch is low. Word bits [23:17] are the chip address, which must equal 0x04. Bit [16] is the direction flag (0 = write, 1 = read). Bits [15:8] are the register address and bits [7:0] are the data.
- R2: The addressed register takes the data byte when the latch rises after exactly 24 bits of a matching write frame, and not before. On `cfgOut`, registers 0 to 4 sit in bytes 0 to 4 and registers 14 to 16 sit in bytes 5 to 7, where byte k is `cfgOut[8k+7:8k]`.
- R3: In a matching read, the addressed byte appears on `spiDout` MSB first. Each bit is launched after a falling serial-clock edge, beginning with the falling edge after the 16th rising edge. The master samples the bits at rising edges 17 to 24.
- R4: `spiDoutEn` is high only inside a matching read frame, from its 16th bit on. It returns low once the latch rises.
- R5: A frame whose chip address is not 0x04 changes no register, and `spiDoutEn` stays low throughout it.
- R6: A write frame of fewer or more than 24 bits changes no register.
- R7: Writes to reserved addresses (5 to 13, and anything above 16) change no byte of `cfgOut`. Reads from those addresses return 0x00.
- R8: Reading register 1 returns `pllLocked` in bit 3. Writing bit 3 of register 1 has no effect, and `cfgOut` bit 11 stays 0. The other seven bits of register 1 are writable.
- R9: While `rstN` is low, and immediately after reset, every register is 0x00 and `spiDoutEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rstN | input | 1 | Synchronous active-low reset |
| spiClk | input | 1 | Serial clock from the master, idle low |
| spiLatchN | input | 1 | Active-low frame latch |
| spiDin | input | 1 | Serial data from the master |
| pllLocked | input | 1 | Lock status, read back as register 1 bit 3 |
| spiDout | output | 1 | Serial readback data |
| spiDoutEn | output | 1 | Drive enable for spiDout (low = high impedance) |
| cfgOut | output | 64 | Stored register contents, one byte per implemented register |

## Verification
Every stored register is visible on `cfgOut`, so a write that lands in the wrong slot or fires too early shows on the bus within a few system clocks of the latch edge. A miscounted bit or a wrong header compare shows up as bus activity after a frame that should have been rejected. A bad read path shows at the port during the same frame: the byte shifted out over rising edges 17 to 24 is wrong, or the drive enable rises when it should not or stays high after the latch rises. The lock bit is read back at both levels of `pllLocked`, and the bus is checked after a write of all ones, so a stored or inverted lock bit is exposed.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  typedef struct packed {
    logic       commit;    // write the addressed register
    logic       loadRd;    // load the read byte into the output shifter
    logic       shiftRd;   // advance the output shifter by one bit
    logic       frameEnd;  // latch is high: no frame is in progress
    logic [7:0] addr;
    logic [7:0] data;
  } ctlStb_t;
endpackage

// File: rtl/spi_ctl_frontend.sv
module spi_ctl_frontend
  import spi_ctl_pkg::*;
#(
  parameter logic [6:0] CHIP_ADDR = 7'h04,
  parameter int         FRAME_BITS = 24
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    spiClk,
  input  logic    spiLatchN,
  input  logic    spiDin,
  output ctlStb_t stb
);
  localparam int CNT_W = $clog2(FRAME_BITS + 2);
  localparam int HDR_BITS = FRAME_BITS - 8;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [2:0] clkS;
  logic [2:0] latS;
  logic [1:0] dinS;
  logic [CNT_W-1:0] bitCnt;
  logic [FRAME_BITS-1:0] shReg;
  logic sclkRise, sclkFall, inFrame, latRise, hdrRead, hdrWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkS <= '0;
      latS <= '1;
      dinS <= '0;
    end else begin
      clkS <= {clkS[1:0], spiClk};
      latS <= {latS[1:0], spiLatchN};
      dinS <= {dinS[0], spiDin};
    end
  end

  assign sclkRise = clkS[1] & ~clkS[2];
  assign sclkFall = ~clkS[1] & clkS[2];
  assign inFrame  = ~latS[1];
  assign latRise  = latS[1] & ~latS[2];

  always_ff @(posedge clk) begin
    if (!rstN || !inFrame) begin
      bitCnt <= '0;
    end else if (sclkRise && bitCnt != CNT_MAX) begin
      bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
    end else if (inFrame && sclkRise) begin
      shReg <= {shReg[FRAME_BITS-2:0], dinS[1]};
    end
  end

  assign hdrRead  = shReg[15:8] == {CHIP_ADDR, 1'b1};
  assign hdrWrite = shReg[23:16] == {CHIP_ADDR, 1'b0};

  always_comb begin
    stb.commit   = latRise && bitCnt == CNT_FULL && hdrWrite;
    stb.loadRd   = inFrame && sclkFall && bitCnt == CNT_HDR && hdrRead;
    stb.shiftRd  = inFrame && sclkFall && bitCnt > CNT_HDR && bitCnt <= CNT_FULL;
    stb.frameEnd = ~inFrame;
    stb.addr     = (bitCnt == CNT_HDR) ? shReg[7:0] : shReg[15:8];
    stb.data     = shReg[7:0];
  end
endmodule

// File: rtl/spi_ctl_regbank.sv
module spi_ctl_regbank
  import spi_ctl_pkg::*;
#(
  parameter int LO_COUNT  = 5,
  parameter int HI_BASE   = 14,
  parameter int HI_COUNT  = 3,
  parameter int LOCK_SLOT = 1,
  parameter int LOCK_BIT  = 3
) (
  input  logic    clk,
  input  logic    rstN,
  input  ctlStb_t stb,
  input  logic    pllLocked,
  output logic [(LO_COUNT+HI_COUNT)*8-1:0] cfgOut,
  output logic    spiDout,
  output logic    spiDoutEn
);
  localparam int NUM_REGS = LO_COUNT + HI_COUNT;
  localparam logic [7:0] LOCK_MASK = 8'(1 << LOCK_BIT);

  logic [NUM_REGS-1:0] hit;
  logic [7:0] rdData;
  logic [7:0] txReg;
  logic [1:0] lockS;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gSlot
    localparam int ADDR = (g < LO_COUNT) ? g : HI_BASE + g - LO_COUNT;
    localparam logic [7:0] WMASK = (g == LOCK_SLOT) ? ~LOCK_MASK : 8'hFF;
    logic [7:0] q;
    assign hit[g] = stb.addr == 8'(ADDR);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= '0;
      end else if (stb.commit && hit[g]) begin
        q <= stb.data & WMASK;
      end
    end
    assign cfgOut[g*8 +: 8] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lockS <= '0;
    else       lockS <= {lockS[0], pllLocked};
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit[i]) begin
        rdData = cfgOut[i*8 +: 8];
        if (i == LOCK_SLOT && lockS[1]) rdData = rdData | LOCK_MASK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReg     <= '0;
      spiDoutEn <= 1'b0;
    end else if (stb.frameEnd) begin
      spiDoutEn <= 1'b0;
    end else if (stb.loadRd) begin
      txReg     <= rdData;
      spiDoutEn <= 1'b1;
    end else if (stb.shiftRd && spiDoutEn) begin
      txReg <= {txReg[6:0], 1'b0};
    end
  end

  assign spiDout = txReg[7] & spiDoutEn;
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port
  import spi_ctl_pkg::*;
#(
  parameter logic [6:0] CHIP_ADDR = 7'h04,
  parameter int LO_COUNT  = 5,
  parameter int HI_BASE   = 14,
  parameter int HI_COUNT  = 3,
  parameter int LOCK_SLOT = 1,
  parameter int LOCK_BIT  = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic spiClk,
  input  logic spiLatchN,
  input  logic spiDin,
  input  logic pllLocked,
  output logic spiDout,
  output logic spiDoutEn,
  output logic [(LO_COUNT+HI_COUNT)*8-1:0] cfgOut
);
  localparam int NUM_REGS = LO_COUNT + HI_COUNT;

  ctlStb_t stb;

  spi_ctl_frontend #(.CHIP_ADDR(CHIP_ADDR), .FRAME_BITS(24)) uFront (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiLatchN(spiLatchN),
    .spiDin(spiDin), .stb(stb)
  );

  spi_ctl_regbank #(
    .LO_COUNT(LO_COUNT), .HI_BASE(HI_BASE), .HI_COUNT(HI_COUNT),
    .LOCK_SLOT(LOCK_SLOT), .LOCK_BIT(LOCK_BIT)
  ) uBank (
    .clk(clk), .rstN(rstN), .stb(stb), .pllLocked(pllLocked),
    .cfgOut(cfgOut), .spiDout(spiDout), .spiDoutEn(spiDoutEn)
  );
endmodule

// File: rtl/spi_ctl_port_chk.sv
module spi_ctl_port_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rstN,
  input logic         spiClk,
  input logic         spiLatchN,
  input logic         spiDout,
  input logic         spiDoutEn,
  input logic [W-1:0] cfgOut
);
  AST_OE_RISES_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    $rose(spiDoutEn) |-> !spiLatchN); // R4

  AST_OE_LOW_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (spiLatchN && $past(spiLatchN, 4)) |-> !spiDoutEn); // R4

  AST_WRITE_ONLY_AFTER_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgOut) |-> spiLatchN); // R2

  AST_DOUT_MOVES_ON_LOW_CLK: assert property (@(posedge clk) disable iff (!rstN)
    (spiDoutEn && $past(spiDoutEn) && !$stable(spiDout)) |-> !spiClk); // R3

  AST_OE_LOW_IN_RESET: assert property (@(posedge clk)
    $past(!rstN) |-> !spiDoutEn); // R9
endmodule

bind spi_ctl_port spi_ctl_port_chk #(.W(NUM_REGS*8)) uChk (
  .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiLatchN(spiLatchN),
  .spiDout(spiDout), .spiDoutEn(spiDoutEn), .cfgOut(cfgOut)
);

// File: tb/sim_spi_ctl_port.sv
`timescale 1ns/1ps
module sim_spi_ctl_port;
  localparam int HALF = 60;
  localparam logic [6:0] CHIP = 7'h04;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic spiClk = 1'b0;
  logic spiLatchN = 1'b1;
  logic spiDin = 1'b0;
  logic pllLocked = 1'b1;
  logic spiDout, spiDoutEn;
  logic [63:0] cfgOut;

  int nChecks = 0;
  int nFails = 0;
  logic [7:0] model [8];

  always #2.5 clk = ~clk;

  spi_ctl_port u0 (
    .clk(clk), .rstN(rstN), .spiClk(spiClk), .spiLatchN(spiLatchN),
    .spiDin(spiDin), .pllLocked(pllLocked), .spiDout(spiDout),
    .spiDoutEn(spiDoutEn), .cfgOut(cfgOut)
  );

  // {address, write data, expected readback}
  localparam logic [23:0] VEC [11] = '{
    {8'h00, 8'h5A, 8'h5A}, {8'h01, 8'hFF, 8'hFF}, {8'h02, 8'h81, 8'h81},
    {8'h03, 8'h3C, 8'h3C}, {8'h04, 8'hC3, 8'hC3}, {8'h0E, 8'h11, 8'h11},
    {8'h0F, 8'hA5, 8'hA5}, {8'h10, 8'h7E, 8'h7E}, {8'h05, 8'hFF, 8'h00},
    {8'h0D, 8'hFF, 8'h00}, {8'h20, 8'h55, 8'h00}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int slotOf(input logic [7:0] a);
    if (a <= 8'd4) return int'(a);
    if (a >= 8'd14 && a <= 8'd16) return int'(a) - 9;
    return -1;
  endfunction

  function automatic logic [63:0] modelFlat();
    logic [63:0] f;
    for (int k = 0; k < 8; k++) f[k*8 +: 8] = model[k];
    return f;
  endfunction

  task automatic frame(input logic [31:0] word, input int nbits,
                       output logic [7:0] rd, output logic oeSeen, output logic oeAfter);
    rd = '0;
    oeSeen = 1'b0;
    spiLatchN = 1'b0;
    for (int i = nbits - 1; i >= 0; i--) begin
      spiDin = word[i];
      #HALF;
      if (spiDoutEn) oeSeen = 1'b1;
      if (nbits - 1 - i >= 16) rd = {rd[6:0], spiDout};
      spiClk = 1'b1;
      #HALF;
      spiClk = 1'b0;
    end
    #HALF;
    spiLatchN = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    oeAfter = spiDoutEn;
  endtask

  task automatic wr(input logic [6:0] chip, input logic [7:0] a, input logic [7:0] d, input int nbits);
    logic [7:0] rd;
    logic s, f;
    frame({8'h00, chip, 1'b0, a, d}, nbits, rd, s, f);
  endtask

  task automatic rdReg(input logic [6:0] chip, input logic [7:0] a,
                       output logic [7:0] rd, output logic s, output logic f);
    frame({8'h00, chip, 1'b1, a, 8'h00}, 24, rd, s, f);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic s, f;
    for (int k = 0; k < 8; k++) model[k] = 8'h00;
    repeat (10) @(posedge clk);
    #1;
    chk("R9 reset cfgOut", cfgOut, 64'h0);
    chk("R9 reset oe", 64'(spiDoutEn), 64'h0);
    rstN = 1'b1;
    repeat (10) @(posedge clk);
    rdReg(CHIP, 8'h00, rd, s, f);
    chk("R9 reg0 after reset", 64'(rd), 64'h0);

    for (int v = 0; v < 11; v++) begin
      logic [7:0] a, d, e;
      int sl;
      {a, d, e} = VEC[v];
      wr(CHIP, a, d, 24);
      sl = slotOf(a);
      if (sl >= 0) model[sl] = (sl == 1) ? (d & 8'hF7) : d;
      chk(sl >= 0 ? "R2 write lands" : "R7 reserved write ignored", cfgOut, modelFlat());
      rdReg(CHIP, a, rd, s, f);
      chk(sl >= 0 ? "R3 readback" : "R7 reserved read zero", 64'(rd), 64'(e));
      chk("R4 oe during read", 64'(s), 64'h1);
      chk("R4 oe after latch", 64'(f), 64'h0);
    end
    chk("R8 lock bit not stored", 64'(cfgOut[11]), 64'h0);

    pllLocked = 1'b0;
    repeat (10) @(posedge clk);
    rdReg(CHIP, 8'h01, rd, s, f);
    chk("R8 lock low readback", 64'(rd), 64'hF7);
    wr(CHIP, 8'h01, 8'h08, 24);
    model[1] = 8'h00;
    chk("R8 lock bit write ignored", cfgOut, modelFlat());
    pllLocked = 1'b1;
    repeat (10) @(posedge clk);
    rdReg(CHIP, 8'h01, rd, s, f);
    chk("R8 lock high readback", 64'(rd), 64'h08);

    wr(7'h05, 8'h00, 8'h00, 24);
    chk("R5 foreign write ignored", cfgOut, modelFlat());
    rdReg(7'h05, 8'h00, rd, s, f);
    chk("R5 foreign read keeps oe low", 64'(s), 64'h0);
    rdReg(7'h02, 8'h00, rd, s, f);
    chk("R1 chip address compare", 64'(s), 64'h0);

    wr(CHIP, 8'h00, 8'h00, 23);
    chk("R6 short frame ignored", cfgOut, modelFlat());
    frame({7'h00, CHIP, 1'b0, 8'h00, 8'h00, 1'b0}, 25, rd, s, f);
    chk("R6 long frame ignored", cfgOut, modelFlat());
    wr(CHIP, 8'h00, 8'hE7, 24);
    model[0] = 8'hE7;
    chk("R1 field positions", cfgOut, modelFlat());

    rstN = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    chk("R9 mid-run reset cfgOut", cfgOut, 64'h0);
    chk("R9 mid-run reset oe", 64'(spiDoutEn), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule